// File: doc/BRIEF.md
# Memory Dependence Wakeup Tracker

This block tracks in-flight memory operations of an out-of-order core: loads, stores, full memory barriers and write barriers. Each operation carries a sequence number and a thread ID. When an operation is inserted, the block decides whether it has to wait on an older producer. The producer is either an active barrier or a store that an external predictor names through a sequence-number input. A predictor value of zero means no producer.

An operation is released to the issue side once two conditions hold: its registers are ready and its memory dependence is resolved. When a producer completes, it wakes every operation that waits on it. A squash removes the younger operations of one thread. A reschedule/replay pair sends operations that were already released back to the issue side a second time.

Released operations are held as pending bits in the entry table. A one-entry valid/ready output stage drains them, lowest table slot first. Insert, register-ready, complete and reschedule each name their entry by sequence number, so sequence numbers must be unique among tracked entries. The table has a fixed number of slots, and insert is refused when every slot is in use.

Top module: `memdep_tracker`

## Requirements
- R1: The insert kind is encoded as 0 = load, 1 = store, 2 = full barrier, 3 = write barrier. Inserting a full barrier arms both a load block and a store block and records its sequence number for each. Inserting a write barrier arms only the store block. Barriers themselves are never released on the output.
- R2: The producer of an inserted load is the load-block sequence number while the load block is armed. The producer of an inserted store is the store-block sequence number while the store block is armed. In every other case the producer is `predSeq`, where zero means no producer.
- R3: If the producer is not a tracked entry, the new operation is memory-ready at once. If `insRegsReady` is also high, the operation is released without any further event.
- R4: If the producer is a tracked entry, the new operation waits on it, and its `insRegsReady` value is still recorded.
- R5: A register-ready notification (`rdyValid`, `rdySeq`) marks that entry's registers ready. The entry is released only if it is already memory-ready.
- R6: When a producer completes (`cmpValid`, `cmpSeq`), each dependent with ready registers is released and every other dependent becomes memory-ready. The producer's slot is freed on the following cycle, and a later insert that names it as producer sees no producer.
- R7: Completing a barrier disarms a block only if that block's recorded sequence number equals the barrier's own. A block re-armed by a newer barrier stays armed.
- R8: A squash (`sqValid`, `sqSeq`, `sqTid`) removes every entry of thread `sqTid` whose sequence number is greater than `sqSeq`. A removed entry is never released, even by a later completion or register-ready notification. Inserts are refused during the squash cycle.
- R9: `reschValid`/`reschSeq` marks an entry for replay. `replayReq` releases all marked entries again. A squash discards the marks of the entries it removes.
- R10: `insReady` is low while all table slots are occupied. An insert that is offered while `insReady` is low has no effect.
- R11: Released operations leave through `outValid`/`outReady` in ascending table-slot order. While `outValid` is high and `outReady` is low, `outSeq` and `outTid` hold steady.
- R12: If a producer completes in the same cycle as the register-ready notification for its dependent, that dependent is released exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert request |
| insReady | output | 1 | Insert accepted (a free slot exists and no squash is in progress) |
| insKind | input | 2 | 0 load, 1 store, 2 full barrier, 3 write barrier |
| insSeq | input | SEQ_W | Sequence number of the inserted operation |
| insTid | input | TID_W | Thread of the inserted operation |
| insRegsReady | input | 1 | Source registers are already ready at insert |
| predSeq | input | SEQ_W | Producer store named by the predictor, 0 for none |
| rdyValid | input | 1 | Register-ready notification |
| rdySeq | input | SEQ_W | Entry named by the notification |
| cmpValid | input | 1 | Completion of an entry |
| cmpSeq | input | SEQ_W | Entry that completes |
| reschValid | input | 1 | Mark an entry for replay |
| reschSeq | input | SEQ_W | Entry to mark |
| replayReq | input | 1 | Release all marked entries |
| sqValid | input | 1 | Squash request |
| sqSeq | input | SEQ_W | Squash point; younger entries are removed |
| sqTid | input | TID_W | Thread being squashed |
| outValid | output | 1 | A released operation is presented |
| outReady | input | 1 | Consumer accepts the released operation |
| outSeq | output | SEQ_W | Sequence number of the released operation |
| outTid | output | TID_W | Thread of the released operation |

## Verification
Two functions can fall in the same cycle on the same entry: a producer's completion and the register-ready notification for one of its dependents. If they are treated as separate events, the dependent is either released twice or never released. The bench provokes this by driving `cmpValid` for a store and `rdyValid` for its waiting load in one cycle. It then judges the run by counting the released operations: the load must appear exactly once. In the same vein, two waiting dependents of one barrier that wake in the same cycle must leave in slot order.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD    = 2'd0,
    KIND_STORE   = 2'd1,
    KIND_FULLBAR = 2'd2,
    KIND_WRBAR   = 2'd3
  } opKind_e;

  // strobes from control to the entry table
  typedef struct packed {
    logic doInsert;
    logic prodFound;
    logic insRelease;
    logic replayAll;
  } tblStrobe_t;

endpackage

// File: rtl/memdep_ctrl.sv
module memdep_ctrl
  import memdep_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int SEQ_W = 16,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  opKind_e           insKind,
  input  logic [SEQ_W-1:0]  insSeq,
  input  logic              insRegsReady,
  input  logic [SEQ_W-1:0]  predSeq,
  input  logic              sqValid,
  input  logic              replayReq,
  input  logic              cmpValid,
  input  logic [SEQ_W-1:0]  cmpSeq,
  input  logic [SLOTS-1:0]  validVec,
  input  logic [SLOTS-1:0]  prodHit,
  input  logic              cmpBarHit,
  output logic              insReady,
  output logic [SEQ_W-1:0]  prodSeq,
  output logic [SLOT_W-1:0] allocIdx,
  output tblStrobe_t        strobe
);

  logic             ldBlock, stBlock;
  logic [SEQ_W-1:0] ldBlockSeq, stBlockSeq;
  logic             tableFull;

  // producer selection: barrier blocks win over the predictor
  always_comb begin
    prodSeq = '0;
    case (insKind)
      KIND_LOAD:  prodSeq = ldBlock ? ldBlockSeq : predSeq;
      KIND_STORE: prodSeq = stBlock ? stBlockSeq : predSeq;
      default:    prodSeq = '0;
    endcase
  end

  // lowest free slot
  always_comb begin
    allocIdx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!validVec[i]) allocIdx = SLOT_W'(i);
    end
  end

  assign tableFull = &validVec;
  assign insReady  = !tableFull && !sqValid;

  always_comb begin
    strobe.doInsert   = insValid && insReady;
    strobe.prodFound  = |prodHit;
    strobe.insRelease = !(|prodHit) && insRegsReady && !insKind[1];
    strobe.replayAll  = replayReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldBlock    <= 1'b0;
      stBlock    <= 1'b0;
      ldBlockSeq <= '0;
      stBlockSeq <= '0;
    end else begin
      if (cmpValid && cmpBarHit) begin
        if (ldBlockSeq == cmpSeq) ldBlock <= 1'b0;
        if (stBlockSeq == cmpSeq) stBlock <= 1'b0;
      end
      if (strobe.doInsert && insKind == KIND_FULLBAR) begin
        ldBlock    <= 1'b1;
        ldBlockSeq <= insSeq;
        stBlock    <= 1'b1;
        stBlockSeq <= insSeq;
      end else if (strobe.doInsert && insKind == KIND_WRBAR) begin
        stBlock    <= 1'b1;
        stBlockSeq <= insSeq;
      end
    end
  end

  // R1: a full barrier arms both blocks
  a_r1_fullbar_arms: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doInsert && insKind == KIND_FULLBAR) |=> (ldBlock && stBlock));

  // R10: never allocate an occupied slot
  a_r10_alloc_free: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doInsert |-> !validVec[allocIdx]);

endmodule

// File: rtl/memdep_table.sv
module memdep_table
  import memdep_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int SEQ_W = 16,
  parameter int TID_W = 2,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tblStrobe_t        strobe,
  input  logic [SLOT_W-1:0] allocIdx,
  input  opKind_e           insKind,
  input  logic [SEQ_W-1:0]  insSeq,
  input  logic [TID_W-1:0]  insTid,
  input  logic              insRegsReady,
  input  logic [SEQ_W-1:0]  prodSeq,
  input  logic              rdyValid,
  input  logic [SEQ_W-1:0]  rdySeq,
  input  logic              cmpValid,
  input  logic [SEQ_W-1:0]  cmpSeq,
  input  logic              reschValid,
  input  logic [SEQ_W-1:0]  reschSeq,
  input  logic              sqValid,
  input  logic [SEQ_W-1:0]  sqSeq,
  input  logic [TID_W-1:0]  sqTid,
  input  logic [SLOTS-1:0]  popOH,
  output logic [SLOTS-1:0]  validVec,
  output logic [SLOTS-1:0]  prodHit,
  output logic              cmpBarHit,
  output logic [SLOTS-1:0]  pendOut,
  output logic [SEQ_W-1:0]  seqArr [SLOTS],
  output logic [TID_W-1:0]  tidArr [SLOTS]
);

  logic [SLOTS-1:0] regsRdy, memRdy, pend, replayMark;
  opKind_e          kindArr [SLOTS];
  logic [SLOTS-1:0] depMask [SLOTS];
  logic [SLOTS-1:0] cmpHit, rdyHit, reschHit, killHit, isBar, wakeVec;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      cmpHit[s]   = cmpValid && validVec[s] && seqArr[s] == cmpSeq;
      rdyHit[s]   = rdyValid && validVec[s] && seqArr[s] == rdySeq;
      reschHit[s] = reschValid && validVec[s] && seqArr[s] == reschSeq;
      killHit[s]  = sqValid && validVec[s] && tidArr[s] == sqTid && seqArr[s] > sqSeq;
      isBar[s]    = kindArr[s][1];
      prodHit[s]  = (prodSeq != '0) && validVec[s] && seqArr[s] == prodSeq
                    && !cmpHit[s] && !killHit[s];
    end
  end

  // dependents woken by the completing producer
  always_comb begin
    wakeVec = '0;
    for (int p = 0; p < SLOTS; p++) begin
      if (cmpHit[p]) wakeVec = wakeVec | depMask[p];
    end
  end

  assign cmpBarHit = |(cmpHit & isBar);
  assign pendOut   = pend & ~killHit & ~cmpHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec   <= '0;
      regsRdy    <= '0;
      memRdy     <= '0;
      pend       <= '0;
      replayMark <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        depMask[s] <= '0;
        seqArr[s]  <= '0;
        tidArr[s]  <= '0;
        kindArr[s] <= KIND_LOAD;
      end
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (cmpHit[s] || killHit[s]) begin
          validVec[s]   <= 1'b0;
          pend[s]       <= 1'b0;
          replayMark[s] <= 1'b0;
          depMask[s]    <= '0;
        end else if (validVec[s]) begin
          regsRdy[s] <= regsRdy[s] | rdyHit[s];
          memRdy[s]  <= memRdy[s] | wakeVec[s];
          pend[s]    <= (pend[s] && !popOH[s])
                        || (!isBar[s] && (regsRdy[s] | rdyHit[s]) && (memRdy[s] | wakeVec[s])
                            && !(regsRdy[s] && memRdy[s]))
                        || (strobe.replayAll && replayMark[s]);
          replayMark[s] <= (replayMark[s] && !strobe.replayAll) || reschHit[s];
        end
      end
      if (strobe.doInsert) begin
        validVec[allocIdx]   <= 1'b1;
        kindArr[allocIdx]    <= insKind;
        seqArr[allocIdx]     <= insSeq;
        tidArr[allocIdx]     <= insTid;
        regsRdy[allocIdx]    <= insRegsReady;
        memRdy[allocIdx]     <= !strobe.prodFound;
        pend[allocIdx]       <= strobe.insRelease;
        replayMark[allocIdx] <= 1'b0;
        depMask[allocIdx]    <= '0;
        for (int p = 0; p < SLOTS; p++) begin
          depMask[p][allocIdx] <= prodHit[p];
        end
      end
    end
  end

  // R6: a completing entry's slot is free on the next cycle
  a_r6_slot_freed: assert property (@(posedge clk) disable iff (!rstN)
    (|cmpHit) |=> ((validVec & $past(cmpHit)) == '0));

  // R8: squashed entries are gone on the next cycle
  a_r8_squash_removes: assert property (@(posedge clk) disable iff (!rstN)
    (|killHit) |=> ((validVec & $past(killHit)) == '0));

  // R5: a pending release always has both readiness conditions
  a_r5_pend_needs_both: assert property (@(posedge clk) disable iff (!rstN)
    ((pend & ~(regsRdy & memRdy)) == '0));

endmodule

// File: rtl/memdep_out.sv
module memdep_out #(
  parameter int SLOTS = 16,
  parameter int SEQ_W = 16,
  parameter int TID_W = 2,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOTS-1:0]  pendOut,
  input  logic [SEQ_W-1:0]  seqArr [SLOTS],
  input  logic [TID_W-1:0]  tidArr [SLOTS],
  input  logic              outReady,
  output logic              outValid,
  output logic [SEQ_W-1:0]  outSeq,
  output logic [TID_W-1:0]  outTid,
  output logic [SLOTS-1:0]  popOH
);

  logic              canLoad, anyPend;
  logic [SLOT_W-1:0] pickIdx;

  assign canLoad = !outValid || outReady;
  assign anyPend = |pendOut;

  always_comb begin
    pickIdx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pendOut[i]) pickIdx = SLOT_W'(i);
    end
  end

  assign popOH = (canLoad && anyPend) ? (SLOTS'(1) << pickIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSeq   <= '0;
      outTid   <= '0;
    end else if (canLoad) begin
      outValid <= anyPend;
      if (anyPend) begin
        outSeq <= seqArr[pickIdx];
        outTid <= tidArr[pickIdx];
      end
    end
  end

  // R11: output holds under backpressure
  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outSeq) && $stable(outTid)));

  // R11: at most one slot drained per cycle
  a_r11_one_pop: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(popOH));

endmodule

// File: rtl/memdep_tracker.sv
module memdep_tracker
  import memdep_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int SEQ_W = 16,
  parameter int TID_W = 2,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  output logic             insReady,
  input  logic [1:0]       insKind,
  input  logic [SEQ_W-1:0] insSeq,
  input  logic [TID_W-1:0] insTid,
  input  logic             insRegsReady,
  input  logic [SEQ_W-1:0] predSeq,
  input  logic             rdyValid,
  input  logic [SEQ_W-1:0] rdySeq,
  input  logic             cmpValid,
  input  logic [SEQ_W-1:0] cmpSeq,
  input  logic             reschValid,
  input  logic [SEQ_W-1:0] reschSeq,
  input  logic             replayReq,
  input  logic             sqValid,
  input  logic [SEQ_W-1:0] sqSeq,
  input  logic [TID_W-1:0] sqTid,
  output logic             outValid,
  input  logic             outReady,
  output logic [SEQ_W-1:0] outSeq,
  output logic [TID_W-1:0] outTid
);

  opKind_e           kindIn;
  tblStrobe_t        strobe;
  logic [SLOT_W-1:0] allocIdx;
  logic [SEQ_W-1:0]  prodSeq;
  logic [SLOTS-1:0]  validVec, prodHit, pendOut, popOH;
  logic              cmpBarHit;
  logic [SEQ_W-1:0]  seqArr [SLOTS];
  logic [TID_W-1:0]  tidArr [SLOTS];

  assign kindIn = opKind_e'(insKind);

  memdep_ctrl #(.SLOTS(SLOTS), .SEQ_W(SEQ_W)) u_ctrl (
    .clk, .rstN, .insValid, .insKind(kindIn), .insSeq, .insRegsReady, .predSeq,
    .sqValid, .replayReq, .cmpValid, .cmpSeq, .validVec, .prodHit, .cmpBarHit,
    .insReady, .prodSeq, .allocIdx, .strobe
  );

  memdep_table #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_table (
    .clk, .rstN, .strobe, .allocIdx, .insKind(kindIn), .insSeq, .insTid,
    .insRegsReady, .prodSeq, .rdyValid, .rdySeq, .cmpValid, .cmpSeq,
    .reschValid, .reschSeq, .sqValid, .sqSeq, .sqTid, .popOH,
    .validVec, .prodHit, .cmpBarHit, .pendOut, .seqArr, .tidArr
  );

  memdep_out #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_out (
    .clk, .rstN, .pendOut, .seqArr, .tidArr, .outReady,
    .outValid, .outSeq, .outTid, .popOH
  );

endmodule

// File: tb/memdep_tracker_bench.sv
module memdep_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEQ_W = 16;
  localparam int TID_W = 2;

  localparam logic [1:0] OP_INS = 2'd0, OP_RDY = 2'd1, OP_CMP = 2'd2;
  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_FB = 2'd2, K_WB = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  kind;
    logic [15:0] seq;
    logic [15:0] pred;
    logic        regs;
    logic [15:0] e1;
    logic [15:0] e2;
    logic [3:0]  req;
  } row_t;

  // e1/e2: expected releases in order (0 = none)
  localparam row_t ROWS [23] = '{
    '{OP_INS, K_LD, 16'd10, 16'd0,  1'b1, 16'd10, 16'd0, 4'd3},  // R3
    '{OP_INS, K_LD, 16'd11, 16'd0,  1'b0, 16'd0,  16'd0, 4'd3},  // R3
    '{OP_RDY, K_LD, 16'd11, 16'd0,  1'b0, 16'd11, 16'd0, 4'd5},  // R5
    '{OP_INS, K_ST, 16'd20, 16'd0,  1'b1, 16'd20, 16'd0, 4'd3},  // R3
    '{OP_INS, K_LD, 16'd21, 16'd20, 1'b1, 16'd0,  16'd0, 4'd4},  // R4
    '{OP_INS, K_LD, 16'd22, 16'd20, 1'b0, 16'd0,  16'd0, 4'd4},  // R4
    '{OP_CMP, K_LD, 16'd20, 16'd0,  1'b0, 16'd21, 16'd0, 4'd6},  // R6
    '{OP_RDY, K_LD, 16'd22, 16'd0,  1'b0, 16'd22, 16'd0, 4'd5},  // R5
    '{OP_INS, K_LD, 16'd23, 16'd20, 1'b1, 16'd23, 16'd0, 4'd6},  // R6 freed producer
    '{OP_INS, K_FB, 16'd30, 16'd0,  1'b1, 16'd0,  16'd0, 4'd1},  // R1
    '{OP_INS, K_LD, 16'd31, 16'd0,  1'b1, 16'd0,  16'd0, 4'd2},  // R2
    '{OP_INS, K_ST, 16'd32, 16'd0,  1'b1, 16'd0,  16'd0, 4'd2},  // R2
    '{OP_INS, K_WB, 16'd40, 16'd0,  1'b1, 16'd0,  16'd0, 4'd1},  // R1
    '{OP_CMP, K_LD, 16'd30, 16'd0,  1'b0, 16'd31, 16'd32, 4'd11},// R11 slot order
    '{OP_INS, K_ST, 16'd41, 16'd0,  1'b1, 16'd0,  16'd0, 4'd7},  // R7 store block kept
    '{OP_INS, K_LD, 16'd42, 16'd0,  1'b1, 16'd42, 16'd0, 4'd7},  // R7 load block dropped
    '{OP_CMP, K_LD, 16'd40, 16'd0,  1'b0, 16'd41, 16'd0, 4'd6},  // R6
    '{OP_INS, K_FB, 16'd50, 16'd0,  1'b1, 16'd0,  16'd0, 4'd1},  // R1
    '{OP_INS, K_WB, 16'd51, 16'd0,  1'b1, 16'd0,  16'd0, 4'd1},  // R1
    '{OP_CMP, K_LD, 16'd50, 16'd0,  1'b0, 16'd0,  16'd0, 4'd7},  // R7
    '{OP_INS, K_ST, 16'd52, 16'd0,  1'b1, 16'd0,  16'd0, 4'd7},  // R7 newer block stays
    '{OP_INS, K_LD, 16'd53, 16'd0,  1'b1, 16'd53, 16'd0, 4'd7},  // R7
    '{OP_CMP, K_LD, 16'd51, 16'd0,  1'b0, 16'd52, 16'd0, 4'd6}   // R6
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic insValid = 0, insRegsReady = 0, rdyValid = 0, cmpValid = 0;
  logic reschValid = 0, replayReq = 0, sqValid = 0, outReady = 1;
  logic [1:0] insKind = 0;
  logic [SEQ_W-1:0] insSeq = 0, predSeq = 0, rdySeq = 0, cmpSeq = 0, reschSeq = 0, sqSeq = 0;
  logic [TID_W-1:0] insTid = 0, sqTid = 0;
  logic insReady, outValid;
  logic [SEQ_W-1:0] outSeq;
  logic [TID_W-1:0] outTid;

  int checks = 0, fails = 0, cycles = 0;
  int capN = 0;
  logic [SEQ_W-1:0] cap [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  memdep_tracker u_memdep_tracker (
    .clk, .rstN, .insValid, .insReady, .insKind, .insSeq, .insTid, .insRegsReady,
    .predSeq, .rdyValid, .rdySeq, .cmpValid, .cmpSeq, .reschValid, .reschSeq,
    .replayReq, .sqValid, .sqSeq, .sqTid, .outValid, .outReady, .outSeq, .outTid
  );

  always @(negedge clk) begin
    if (rstN && outValid && outReady && capN < 32) begin
      cap[capN] = outSeq;
      capN++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    settle(2);
    rstN = 1;
    capN = 0;
  endtask

  task automatic doIns(input logic [1:0] k, input int s, input int t, input bit r, input int p);
    insValid = 1; insKind = k; insSeq = SEQ_W'(s); insTid = TID_W'(t);
    insRegsReady = r; predSeq = SEQ_W'(p);
    @(negedge clk);
    insValid = 0; insRegsReady = 0; predSeq = 0;
  endtask

  task automatic doRdy(input int s);
    rdyValid = 1; rdySeq = SEQ_W'(s);
    @(negedge clk);
    rdyValid = 0;
  endtask

  task automatic doCmp(input int s);
    cmpValid = 1; cmpSeq = SEQ_W'(s);
    @(negedge clk);
    cmpValid = 0;
  endtask

  task automatic doSq(input int s, input int t);
    sqValid = 1; sqSeq = SEQ_W'(s); sqTid = TID_W'(t);
    @(negedge clk);
    sqValid = 0;
  endtask

  task automatic doResch(input int s);
    reschValid = 1; reschSeq = SEQ_W'(s);
    @(negedge clk);
    reschValid = 0;
  endtask

  task automatic doReplay();
    replayReq = 1;
    @(negedge clk);
    replayReq = 0;
  endtask

  task automatic expectCaps(input string req, input int n, input int a, input int b);
    settle(4);
    chk(capN == n, req, capN, n);
    if (n >= 1 && capN >= 1) chk(cap[0] == SEQ_W'(a), req, int'(cap[0]), a);
    if (n >= 2 && capN >= 2) chk(cap[1] == SEQ_W'(b), req, int'(cap[1]), b);
    capN = 0;
  endtask

  initial begin
    doReset();
    // reset state
    chk(outValid == 1'b0, "R11 reset outValid", int'(outValid), 0);
    chk(insReady == 1'b1, "R10 reset insReady", int'(insReady), 1);

    // vector table walk
    for (int i = 0; i < 23; i++) begin
      row_t rw;
      int n;
      rw = ROWS[i];
      case (rw.op)
        OP_INS:  doIns(rw.kind, int'(rw.seq), 0, rw.regs, int'(rw.pred));
        OP_RDY:  doRdy(int'(rw.seq));
        default: doCmp(int'(rw.seq));
      endcase
      n = (rw.e1 != 0 ? 1 : 0) + (rw.e2 != 0 ? 1 : 0);
      expectCaps($sformatf("R%0d row %0d", rw.req, i), n, int'(rw.e1), int'(rw.e2));
    end

    // R10: fill the table, refused insert has no effect
    doReset();
    for (int i = 0; i < 16; i++) doIns(K_LD, 1000 + i, 0, 1'b0, 0);
    chk(insReady == 1'b0, "R10 full", int'(insReady), 0);
    doIns(K_LD, 2000, 0, 1'b1, 0);
    expectCaps("R10 refused insert", 0, 0, 0);
    doSq(1007, 0);
    settle(1);
    chk(insReady == 1'b1, "R10 ready after free", int'(insReady), 1);
    doRdy(1003);
    expectCaps("R10 table intact", 1, 1003, 0);

    // R8: squash by thread and sequence
    doReset();
    doIns(K_ST, 100, 0, 1'b1, 0);
    expectCaps("R8 store", 1, 100, 0);
    doIns(K_LD, 101, 0, 1'b1, 100);
    doIns(K_LD, 102, 1, 1'b1, 100);
    doIns(K_LD, 103, 0, 1'b0, 0);
    doSq(100, 0);
    doRdy(103);
    expectCaps("R8 squashed not released by notify", 0, 0, 0);
    doCmp(100);
    expectCaps("R8 only other thread woken", 1, 102, 0);

    // R9: replay in slot order, squash drops mark
    doReset();
    doIns(K_LD, 200, 0, 1'b1, 0);
    doIns(K_LD, 201, 0, 1'b1, 0);
    expectCaps("R9 initial", 2, 200, 201);
    doResch(201);
    doResch(200);
    doReplay();
    expectCaps("R9 replay order", 2, 200, 201);
    doResch(201);
    doSq(200, 0);
    doReplay();
    expectCaps("R9 squash drops replay", 0, 0, 0);

    // R12: completion and register-ready in one cycle
    doReset();
    doIns(K_ST, 300, 0, 1'b1, 0);
    doIns(K_LD, 301, 0, 1'b0, 300);
    expectCaps("R12 setup", 1, 300, 0);
    cmpValid = 1; cmpSeq = 300; rdyValid = 1; rdySeq = 301;
    @(negedge clk);
    cmpValid = 0; rdyValid = 0;
    expectCaps("R12 single release", 1, 301, 0);

    // R11: backpressure holds output
    doReset();
    outReady = 0;
    doIns(K_LD, 500, 2, 1'b1, 0);
    doIns(K_LD, 501, 1, 1'b1, 0);
    settle(3);
    chk(outValid == 1'b1, "R11 valid under stall", int'(outValid), 1);
    chk(outSeq == 16'd500, "R11 held seq", int'(outSeq), 500);
    chk(outTid == 2'd2, "R11 held tid", int'(outTid), 2);
    settle(3);
    chk(outSeq == 16'd500, "R11 still held", int'(outSeq), 500);
    outReady = 1;
    expectCaps("R11 drain order", 2, 500, 501);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule